// File: doc/BRIEF.md
# Pulse-Handshake Bus Ownership Arbiter

This block lets a host processor hand its local bus to one of several other bus masters, using only one shared active-low wire per channel. A master asks for the bus by pulling its wire low for exactly one clock. The arbiter answers on the same wire with a one-clock low pulse at a legal point in the host's bus cycle. From the next clock it floats the host's bus drivers. When the master is finished it pulses the wire low for one more clock. The host takes the bus back on the following clock.

The wire is modelled as a sampled input and a separate drive-low enable. An undriven wire reads high because of an external pull-up. The host's bus phase, its lock flag and two flags that forbid release at the end of the current cycle (the first half of a split word transfer, the first interrupt-acknowledge cycle) come in as inputs. The sequencer that produces them is outside this block.

Channel 0 wins over higher channels when requests are pending together. The losing request is kept and served later. Every exchange is followed by at least `DEAD_CLKS` idle clocks before another grant can go out.

Top module: `rqgt_arbiter`

## Requirements
- R1: While `rstN` is low, and after it rises with no request seen, `chDriveLow`, `busFloat` and `ownerOh` are all zero.
- R2: A grant drives exactly one bit of `chDriveLow` for a single clock. A channel whose request is already pending ignores further low samples until it is granted.
- R3: Phase encoding on `busPhase` is 0 idle, 1 T1, 2 T2, 3 T3, 4 T4, 5 wait. A request sampled in idle, T1 or T2 is granted in the T4 of the running cycle. A request first sampled in T3, T4 or a wait clock is not granted in that T4 and is granted in the next T1.
- R4: From the clock after a grant, `busFloat` is high and `ownerOh` holds the granted channel as a one-hot value, until the bus is regained.
- R5: A low sample on the owner's wire while `busFloat` is high is a release. On the next clock `busFloat` and `ownerOh` return to zero, and the release does not count as a new request.
- R6: For `DEAD_CLKS` clocks after the bus is regained, no grant is issued, even if a request is pending.
- R7: When several channels are eligible in the same clock, the lowest-numbered one is granted. The others stay pending and are granted once the exchange and its dead clocks are over.
- R8: No grant is issued in any clock where `lockIn` is high. Requests seen meanwhile stay pending.
- R9: In a T4 where `splitWordIn` or `intaFirstIn` is high, no grant is issued, and none in the clock that follows. The request is served at the next legal point.
- R10: With `busPhase` idle, a pending request is granted in the first clock after it is sampled.
- R11: The arbiter drives a channel's wire only in that channel's grant clock. It never takes its own drive as a request or a release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busPhase | input | 3 | Host bus phase of the current clock (encoding in R3) |
| lockIn | input | 1 | Host is running a locked instruction; bus may not be released |
| splitWordIn | input | 1 | Current cycle is the first half of a word split over two cycles |
| intaFirstIn | input | 1 | Current cycle is the first interrupt-acknowledge cycle |
| chLineIn | input | NUM_CH | Sampled level of each channel wire; low means asserted |
| chDriveLow | output | NUM_CH | Drive-low enable per channel wire (the grant pulse) |
| busFloat | output | 1 | Host bus drivers are floated; a master owns the bus |
| ownerOh | output | NUM_CH | One-hot owner of the bus while floated |

## Verification
The bench targets the timing boundaries of the grant. A request that arrives in T2 must be granted in that cycle's T4, and one that arrives in T3 must wait for the following T1; a design that ignored this would grant one cycle early or late. It checks that the dead clock after a regain holds back a request already queued from another channel, and that the lower channel wins a tie while the loser is kept rather than dropped. It also holds a grant off through lock, through a split-word T4 and through a first-acknowledge T4 with the clock after it. Repeated low pulses on a channel that is already pending must not produce a second grant. Each of these faults shows up as a grant pulse in the wrong clock or on the wrong wire, or as a missing grant, when the outputs are compared with the model on every clock.

// File: rtl/rqgt_pkg.sv
package rqgt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4,
    PH_TW   = 3'd5
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fire;     // issue a grant this clock
    logic useT4;    // grant chosen from requests eligible at T4
    logic holding;  // bus currently lent out
    logic regain;   // owner release seen this clock
  } rqgt_strobe_t;

endpackage

// File: rtl/rqgt_ctrl.sv
module rqgt_ctrl
  import rqgt_pkg::*;
#(
  parameter int DEAD_CLKS = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   busPhase,
  input  logic         lockIn,
  input  logic         splitWordIn,
  input  logic         intaFirstIn,
  input  logic         anyT4,
  input  logic         anyPend,
  input  logic         releaseSeen,
  output rqgt_strobe_t strb,
  output logic         busFloat
);

  localparam int DW = (DEAD_CLKS < 1) ? 1 : $clog2(DEAD_CLKS + 1);

  logic          holding;
  logic [DW-1:0] deadCnt;
  logic          blockNext;
  logic          isT4;
  logic          isOpen;
  logic          t4Ok;
  logic          openOk;
  logic          fire;
  logic          regain;

  always_comb begin
    isT4   = (busPhase == PH_T4);
    isOpen = (busPhase == PH_T1) || (busPhase == PH_IDLE);
    t4Ok   = isT4 && !splitWordIn && !intaFirstIn && anyT4;
    openOk = isOpen && !blockNext && anyPend;
    fire   = !holding && (deadCnt == '0) && !lockIn && (t4Ok || openOk);
    regain = holding && releaseSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holding   <= 1'b0;
      deadCnt   <= '0;
      blockNext <= 1'b0;
    end else begin
      if (fire)        holding <= 1'b1;
      else if (regain) holding <= 1'b0;

      if (regain)               deadCnt <= DW'(DEAD_CLKS);
      else if (deadCnt != '0)   deadCnt <= deadCnt - 1'b1;

      blockNext <= isT4 && (splitWordIn || intaFirstIn);
    end
  end

  always_comb begin
    strb.fire    = fire;
    strb.useT4   = isT4;
    strb.holding = holding;
    strb.regain  = regain;
  end

  assign busFloat = holding;

endmodule

// File: rtl/rqgt_datapath.sv
module rqgt_datapath
  import rqgt_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        busPhase,
  input  logic [NUM_CH-1:0] chLineIn,
  input  rqgt_strobe_t      strb,
  output logic              anyT4,
  output logic              anyPend,
  output logic              releaseSeen,
  output logic [NUM_CH-1:0] grantOh,
  output logic [NUM_CH-1:0] ownerOh
);

  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] late;
  logic [NUM_CH-1:0] lowSeen;
  logic [NUM_CH-1:0] capture;
  logic [NUM_CH-1:0] eligT4;
  logic [NUM_CH-1:0] pickAny;
  logic [NUM_CH-1:0] pickT4;
  logic              latePhase;
  logic              cycleStart;

  always_comb begin
    lowSeen    = ~chLineIn;
    latePhase  = (busPhase == PH_T3) || (busPhase == PH_T4) || (busPhase == PH_TW);
    cycleStart = (busPhase == PH_T1);
    eligT4     = pend & ~late;
    // lowest set bit wins
    pickAny    = pend & (~pend + NUM_CH'(1));
    pickT4     = eligT4 & (~eligT4 + NUM_CH'(1));
    anyPend    = |pend;
    anyT4      = |eligT4;
    grantOh    = strb.fire ? (strb.useT4 ? pickT4 : pickAny) : '0;
    // own drive and owner line are never taken as requests
    capture    = lowSeen & ~grantOh & ~ownerOh & ~pend;
    releaseSeen = strb.holding && |(lowSeen & ownerOh);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pend[c] <= 1'b0;
        late[c] <= 1'b0;
      end else if (grantOh[c]) begin
        pend[c] <= 1'b0;
        late[c] <= 1'b0;
      end else if (capture[c]) begin
        pend[c] <= 1'b1;
        late[c] <= latePhase;
      end else if (cycleStart) begin
        late[c] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ownerOh <= '0;
    else if (strb.fire)   ownerOh <= grantOh;
    else if (strb.regain) ownerOh <= '0;
  end

endmodule

// File: rtl/rqgt_arbiter.sv
module rqgt_arbiter
  import rqgt_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int DEAD_CLKS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        busPhase,
  input  logic              lockIn,
  input  logic              splitWordIn,
  input  logic              intaFirstIn,
  input  logic [NUM_CH-1:0] chLineIn,
  output logic [NUM_CH-1:0] chDriveLow,
  output logic              busFloat,
  output logic [NUM_CH-1:0] ownerOh
);

  rqgt_strobe_t strb;
  logic         anyT4;
  logic         anyPend;
  logic         releaseSeen;

  rqgt_ctrl #(.DEAD_CLKS(DEAD_CLKS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busPhase    (busPhase),
    .lockIn      (lockIn),
    .splitWordIn (splitWordIn),
    .intaFirstIn (intaFirstIn),
    .anyT4       (anyT4),
    .anyPend     (anyPend),
    .releaseSeen (releaseSeen),
    .strb        (strb),
    .busFloat    (busFloat)
  );

  rqgt_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .busPhase    (busPhase),
    .chLineIn    (chLineIn),
    .strb        (strb),
    .anyT4       (anyT4),
    .anyPend     (anyPend),
    .releaseSeen (releaseSeen),
    .grantOh     (chDriveLow),
    .ownerOh     (ownerOh)
  );

endmodule

// File: rtl/rqgt_arbiter_chk.sv
module rqgt_arbiter_chk #(
  parameter int NUM_CH    = 2,
  parameter int DEAD_CLKS = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        busPhase,
  input logic              lockIn,
  input logic              splitWordIn,
  input logic              intaFirstIn,
  input logic [NUM_CH-1:0] chLineIn,
  input logic [NUM_CH-1:0] chDriveLow,
  input logic              busFloat,
  input logic [NUM_CH-1:0] ownerOh
);

  localparam int DW = $clog2(DEAD_CLKS + 2);

  logic [DW-1:0] deadLeft;
  logic          relNow;

  assign relNow = busFloat && |(~chLineIn & ownerOh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               deadLeft <= '0;
    else if (relNow)         deadLeft <= DW'(DEAD_CLKS);
    else if (deadLeft != '0) deadLeft <= deadLeft - 1'b1;
  end

  // R2
  drive_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chDriveLow));

  // R2
  drive_single_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chDriveLow != '0) |=> (chDriveLow == '0));

  // R3
  grant_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chDriveLow != '0) |-> (busPhase == 3'd0 || busPhase == 3'd1 || busPhase == 3'd4));

  // R4
  float_after_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chDriveLow != '0) |=> (busFloat && ownerOh == $past(chDriveLow)));

  // R4
  owner_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    busFloat |-> ($countones(ownerOh) == 1));

  // R5
  regain_chk: assert property (@(posedge clk) disable iff (!rstN)
    relNow |=> !busFloat);

  // R6
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deadLeft != '0) |-> (chDriveLow == '0));

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockIn |-> (chDriveLow == '0));

  // R9
  split_t4_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busPhase == 3'd4 && (splitWordIn || intaFirstIn)) |-> (chDriveLow == '0));

  // R9
  split_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busPhase == 3'd4 && (splitWordIn || intaFirstIn)) |=> (chDriveLow == '0));

  // R11
  no_drive_in_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busFloat |-> (chDriveLow == '0));

endmodule

bind rqgt_arbiter rqgt_arbiter_chk #(.NUM_CH(NUM_CH), .DEAD_CLKS(DEAD_CLKS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busPhase    (busPhase),
  .lockIn      (lockIn),
  .splitWordIn (splitWordIn),
  .intaFirstIn (intaFirstIn),
  .chLineIn    (chLineIn),
  .chDriveLow  (chDriveLow),
  .busFloat    (busFloat),
  .ownerOh     (ownerOh)
);

// File: tb/rqgt_arbiter_tb.sv
module rqgt_arbiter_tb;

  localparam int NCH  = 2;
  localparam int DEAD = 1;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [2:0]     busPhase = 3'd0;
  logic           lockIn = 1'b0;
  logic           splitWordIn = 1'b0;
  logic           intaFirstIn = 1'b0;
  logic [NCH-1:0] mDrv = '0;
  logic [NCH-1:0] chLineIn;
  logic [NCH-1:0] chDriveLow;
  logic           busFloat;
  logic [NCH-1:0] ownerOh;

  // pull-up: low when either side drives
  assign chLineIn = ~(mDrv | chDriveLow);

  always #2.5 clk = ~clk;

  rqgt_arbiter #(.NUM_CH(NCH), .DEAD_CLKS(DEAD)) u_dut (
    .clk(clk), .rstN(rstN), .busPhase(busPhase), .lockIn(lockIn),
    .splitWordIn(splitWordIn), .intaFirstIn(intaFirstIn),
    .chLineIn(chLineIn), .chDriveLow(chDriveLow),
    .busFloat(busFloat), .ownerOh(ownerOh)
  );

  int    checks = 0;
  int    errors = 0;
  int    grantSeen = 0;
  string curReq = "R1";

  // behavioural reference state
  bit mPend[NCH];
  bit mLate[NCH];
  bit mHold = 0;
  int mOwner = 0;
  int mDead = 0;
  bit mBlock = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    int g;
    logic [NCH-1:0] expDrv;
    logic [NCH-1:0] expOwn;
    #1;
    g = -1;
    if (!mHold && mDead == 0 && !lockIn) begin
      if (busPhase == 3'd4) begin
        if (!splitWordIn && !intaFirstIn)
          for (int i = NCH-1; i >= 0; i--) if (mPend[i] && !mLate[i]) g = i;
      end else if ((busPhase == 3'd1 || busPhase == 3'd0) && !mBlock) begin
        for (int i = NCH-1; i >= 0; i--) if (mPend[i]) g = i;
      end
    end
    expDrv = '0;
    if (g >= 0) expDrv[g] = 1'b1;
    expOwn = '0;
    if (mHold) expOwn[mOwner] = 1'b1;
    check(curReq, {27'd0, chDriveLow, busFloat, ownerOh}, {27'd0, expDrv, mHold, expOwn});
    if (chDriveLow != '0) grantSeen++;
    @(posedge clk);
    for (int i = 0; i < NCH; i++) begin
      if (i == g) begin
        mPend[i] = 0; mLate[i] = 0;
      end else if (mDrv[i] && !(mHold && i == mOwner) && !mPend[i]) begin
        mPend[i] = 1;
        mLate[i] = (busPhase == 3'd3 || busPhase == 3'd4 || busPhase == 3'd5);
      end else if (busPhase == 3'd1) begin
        mLate[i] = 0;
      end
    end
    if (mHold && mDrv[mOwner]) begin
      mHold = 0; mDead = DEAD;
    end else begin
      if (g >= 0) begin mHold = 1; mOwner = g; end
      if (mDead > 0) mDead--;
    end
    mBlock = (busPhase == 3'd4) && (splitWordIn || intaFirstIn);
    #1;
  endtask

  task automatic cyc(logic [2:0] ph, logic [NCH-1:0] drv);
    busPhase = ph;
    mDrv = drv;
    step();
    mDrv = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(3'd0, 2'b00);
  endtask

  task automatic expectGrants(string req, int n);
    check(req, grantSeen, n);
    grantSeen = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", {chDriveLow, busFloat, ownerOh}, 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1", {chDriveLow, busFloat, ownerOh}, 0);
    idle(2);
    expectGrants("R1", 0);

    // R10, R4, R5: idle bus handoff on channel 0
    curReq = "R10";
    cyc(3'd0, 2'b01);
    idle(3);
    curReq = "R5";
    cyc(3'd0, 2'b01);
    idle(3);
    expectGrants("R10", 1);

    // R3: request in T2 granted at T4; request in T3 waits for next T1
    curReq = "R3";
    cyc(3'd1, 2'b00); cyc(3'd2, 2'b10); cyc(3'd3, 2'b00); cyc(3'd4, 2'b00);
    idle(2); cyc(3'd0, 2'b10); idle(2);
    cyc(3'd1, 2'b00); cyc(3'd2, 2'b00); cyc(3'd3, 2'b01); cyc(3'd5, 2'b00);
    cyc(3'd4, 2'b00); cyc(3'd1, 2'b00);
    idle(2); cyc(3'd0, 2'b01); idle(2);
    expectGrants("R3", 2);

    // R7: tie goes to channel 0; channel 1 kept and served after dead clock
    curReq = "R7";
    cyc(3'd0, 2'b11);
    idle(3);
    cyc(3'd0, 2'b01);
    idle(3);
    cyc(3'd0, 2'b10);
    idle(2);
    expectGrants("R7", 2);

    // R6: channel 1 queued during hold must not be granted in the dead clock
    curReq = "R6";
    cyc(3'd0, 2'b01);
    idle(1);
    cyc(3'd0, 2'b10);
    idle(1);
    cyc(3'd0, 2'b01);
    idle(1);
    idle(2);
    cyc(3'd0, 2'b10);
    idle(2);
    expectGrants("R6", 2);

    // R8: lock defers the grant
    curReq = "R8";
    lockIn = 1'b1;
    cyc(3'd0, 2'b01);
    idle(4);
    cyc(3'd1, 2'b00); cyc(3'd2, 2'b00); cyc(3'd3, 2'b00); cyc(3'd4, 2'b00);
    expectGrants("R8", 0);
    lockIn = 1'b0;
    idle(2);
    cyc(3'd0, 2'b01);
    idle(2);
    expectGrants("R8", 1);

    // R9: split word at T4 blocks that T4 and the following T1
    curReq = "R9";
    cyc(3'd1, 2'b01); cyc(3'd2, 2'b00); cyc(3'd3, 2'b00);
    splitWordIn = 1'b1; cyc(3'd4, 2'b00); splitWordIn = 1'b0;
    cyc(3'd1, 2'b00);
    expectGrants("R9", 0);
    cyc(3'd2, 2'b00); cyc(3'd3, 2'b00); cyc(3'd4, 2'b00);
    idle(1); cyc(3'd0, 2'b01); idle(2);
    expectGrants("R9", 1);

    // R9: first interrupt acknowledge at T4 blocks it and the next idle clock
    cyc(3'd1, 2'b10); cyc(3'd2, 2'b00); cyc(3'd3, 2'b00);
    intaFirstIn = 1'b1; cyc(3'd4, 2'b00); intaFirstIn = 1'b0;
    cyc(3'd0, 2'b00);
    expectGrants("R9", 0);
    cyc(3'd1, 2'b00);
    idle(1); cyc(3'd0, 2'b10); idle(2);
    expectGrants("R9", 1);

    // R2, R11: repeated pulses while pending give one grant only
    curReq = "R2";
    lockIn = 1'b1;
    cyc(3'd0, 2'b10); idle(1); cyc(3'd0, 2'b10); cyc(3'd0, 2'b10);
    lockIn = 1'b0;
    curReq = "R11";
    idle(3);
    cyc(3'd0, 2'b10);
    idle(4);
    expectGrants("R11", 1);

    summary();
    $finish;
  end

endmodule